// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Unit

This block is the lookup and control path of a direct-mapped cache that behaves close to a 2-way cache. The line array is treated as two halves. An accepted request first probes its own line, the primary line. If that probe misses, the block probes a partner line in the other half, the alternate line, whose index is the primary index with its most significant bit inverted. A match there is a pseudo-hit. It is slower than a normal hit but much cheaper than a refill. If both probes miss, the block asks a backing memory for the word and places it in the cache.

The block keeps recently used data in the faster slot. On a pseudo-hit the primary and alternate lines trade places, so the next access to the same block hits on the first probe. On a refill the new line takes the primary slot and the line it pushes out moves to the alternate slot. Each line holds one data word. Only one access is in flight at a time: the request port is held not-ready for as long as a second probe or a refill is in progress.

Top module: `pac_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first access to any address is a miss.
- R2: When the primary line (index `req_addr[IDX_W-1:0]`) is valid and its tag equals `req_addr[ADDR_W-1:IDX_W-1]`, the block returns `rsp_kind` 01 with the stored word. The response is one cycle after acceptance, so two hits can be accepted on consecutive cycles.
- R3: When the primary probe misses and the alternate line matches, the block returns `rsp_kind` 10 with the alternate line's word, two cycles after acceptance.
- R4: A pseudo-hit swaps the primary and alternate lines. The next access to the same block is a hit, and the block that was in the primary slot now gives a pseudo-hit.
- R5: When both probes miss, `mem_req_valid` rises with `mem_req_addr` equal to the request address and stays high until `mem_rsp_valid`. In the cycle after `mem_rsp_valid`, the block returns `rsp_kind` 00 with `mem_rsp_data`. With a memory that answers on its third cycle of request, the response comes five cycles after acceptance.
- R6: A refill writes the primary line. If the old primary line was valid, it moves to the alternate slot and the old alternate line is dropped. If the old primary line was invalid, the alternate slot is left untouched.
- R7: `req_ready` is 0 from the cycle after a non-hit acceptance until its response. A request presented during that time is neither answered nor installed.
- R8: The alternate index is the primary index with bit IDX_W-1 inverted. Because the stored tag includes that bit, two addresses that differ only in that bit are distinct blocks and can both be resident.
- R9: Each accepted request gets exactly one response, `rsp_valid` pulses for one cycle, and `rsp_kind` is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 00 miss, 01 hit, 10 pseudo-hit |
| rsp_data | output | DATA_W | Returned word |
| mem_req_valid | output | 1 | Refill request, held until answered |
| mem_req_addr | output | ADDR_W | Address to refill |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The bench follows one set through a chain of refills and swaps. A design that placed a refill in the wrong slot, or never moved the displaced line, would report a miss where a pseudo-hit is expected. A design that skipped the swap would keep returning pseudo-hits. A refill into an empty primary line while the alternate is occupied catches a design that overwrites the alternate with an invalid line. Addresses that differ only in the top index bit catch a tag that leaves that bit out, which would give false hits. A request held valid during a refill exposes a design that takes it early. Back-to-back hits and exact latency counts catch an extra pipeline stage.

// File: rtl/pac_pkg.sv
// Package: shared encodings for the pseudo-associative lookup unit.
// Assumes: the response code is consumed by a neighbour, so its values are fixed.
package pac_pkg;

    // Response kind seen at the port (R9: 2'b11 never produced)
    typedef enum logic [1:0] {
        KIND_MISS = 2'b00,
        KIND_HIT  = 2'b01,
        KIND_PHIT = 2'b10
    } kind_e;

    // Sequencer states: first probe, second probe, waiting for refill
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ALT  = 2'b01,
        ST_FILL = 2'b10
    } state_e;

endpackage

// File: rtl/pac_line_store.sv
// Module: line storage with two combinational read ports and two write ports.
// Assumes: the two write ports never target the same line in one cycle
// (the controller writes a primary/alternate pair, which always differ).
module pac_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0][IDX_W-1:0]        rd_idx,
    output logic [1:0]                   rd_vld,
    output logic [1:0][TAG_W-1:0]        rd_tag,
    output logic [1:0][DATA_W-1:0]       rd_data,
    input  logic [1:0]                   wr_en,
    input  logic [1:0][IDX_W-1:0]        wr_idx,
    input  logic [1:0]                   wr_vld,
    input  logic [1:0][TAG_W-1:0]        wr_tag,
    input  logic [1:0][DATA_W-1:0]       wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]              vld_q;
    logic [LINES-1:0][TAG_W-1:0]   tag_q;
    logic [LINES-1:0][DATA_W-1:0]  data_q;

    // Update each line from whichever write port addresses it; reset clears all lines (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            for (int l = 0; l < LINES; l++) begin
                if (wr_en[0] && (wr_idx[0] == IDX_W'(l))) begin
                    vld_q[l]  <= wr_vld[0];
                    tag_q[l]  <= wr_tag[0];
                    data_q[l] <= wr_data[0];
                end else if (wr_en[1] && (wr_idx[1] == IDX_W'(l))) begin
                    vld_q[l]  <= wr_vld[1];
                    tag_q[l]  <= wr_tag[1];
                    data_q[l] <= wr_data[1];
                end
            end
        end
    end

    // Read ports: one per probe location
    generate
        for (genvar p = 0; p < 2; p++) begin : g_rd
            assign rd_vld[p]  = vld_q[rd_idx[p]];
            assign rd_tag[p]  = tag_q[rd_idx[p]];
            assign rd_data[p] = data_q[rd_idx[p]];
        end
    endgenerate

    // R4
    pair_write_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && wr_en[1]) |-> (wr_idx[0] != wr_idx[1]));

endmodule

// File: rtl/pac_match.sv
// Module: tag comparator for one probe location.
// Assumes: the tag includes the top index bit, so a full compare separates the two halves.
module pac_match #(
    parameter int TAG_W = 9
) (
    input  logic             line_vld,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             hit
);
    // A probe matches only on a valid line with an equal full tag (R8)
    always_comb hit = line_vld && (line_tag == want_tag);
endmodule

// File: rtl/pac_ctrl.sv
// Module: probe sequencer, swap and refill placement for the lookup unit.
// Assumes: memory answers eventually while mem_req_valid is held;
// the storage reads are combinational from the indices given here.
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_kind,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     mem_req_valid,
    output logic [ADDR_W-1:0]        mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [DATA_W-1:0]        mem_rsp_data,
    output logic [1:0][IDX_W-1:0]    rd_idx,
    output logic [TAG_W-1:0]         look_tag,
    input  logic [1:0]               hit,
    input  logic [1:0]               rd_vld,
    input  logic [1:0][TAG_W-1:0]    rd_tag,
    input  logic [1:0][DATA_W-1:0]   rd_data,
    output logic [1:0]               wr_en,
    output logic [1:0][IDX_W-1:0]    wr_idx,
    output logic [1:0]               wr_vld,
    output logic [1:0][TAG_W-1:0]    wr_tag,
    output logic [1:0][DATA_W-1:0]   wr_data
);
    localparam int TOP = IDX_W - 1;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic                rsp_valid_q, rsp_valid_d;
    kind_e               kind_q, kind_d;
    logic [DATA_W-1:0]   rdata_q, rdata_d;
    logic [ADDR_W-1:0]   cur_addr;
    logic [IDX_W-1:0]    pri_idx;
    logic [IDX_W-1:0]    alt_idx;
    logic                fire;

    // Port handshake: only the idle state takes a request (R7)
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        fire          = req_valid && req_ready;
        mem_req_valid = (state_q == ST_FILL);
        mem_req_addr  = addr_q;
    end

    // Probe addressing: live address while idle, latched address afterwards (R8)
    always_comb begin
        cur_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
        pri_idx   = cur_addr[IDX_W-1:0];
        alt_idx   = {~pri_idx[TOP], pri_idx[TOP-1:0]};
        look_tag  = cur_addr[ADDR_W-1:IDX_W-1];
        rd_idx[0] = pri_idx;
        rd_idx[1] = alt_idx;
    end

    // Next-state, response and line-write decisions for each state
    always_comb begin
        state_d     = state_q;
        addr_d      = addr_q;
        rsp_valid_d = 1'b0;
        kind_d      = kind_q;
        rdata_d     = rdata_q;
        wr_en       = '0;
        wr_idx[0]   = pri_idx;
        wr_idx[1]   = alt_idx;
        wr_vld      = '0;
        wr_tag      = '0;
        wr_data     = '0;
        case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    addr_d = req_addr;
                    if (hit[0]) begin
                        rsp_valid_d = 1'b1;
                        kind_d      = KIND_HIT;
                        rdata_d     = rd_data[0];
                    end else begin
                        state_d = ST_ALT;
                    end
                end
            end
            ST_ALT: begin
                if (hit[1]) begin
                    wr_en      = 2'b11;
                    wr_vld[0]  = rd_vld[1];
                    wr_tag[0]  = rd_tag[1];
                    wr_data[0] = rd_data[1];
                    wr_vld[1]  = rd_vld[0];
                    wr_tag[1]  = rd_tag[0];
                    wr_data[1] = rd_data[0];
                    rsp_valid_d = 1'b1;
                    kind_d      = KIND_PHIT;
                    rdata_d     = rd_data[1];
                    state_d     = ST_IDLE;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    wr_en[0]   = 1'b1;
                    wr_vld[0]  = 1'b1;
                    wr_tag[0]  = look_tag;
                    wr_data[0] = mem_rsp_data;
                    wr_en[1]   = rd_vld[0];
                    wr_vld[1]  = 1'b1;
                    wr_tag[1]  = rd_tag[0];
                    wr_data[1] = rd_data[0];
                    rsp_valid_d = 1'b1;
                    kind_d      = KIND_MISS;
                    rdata_d     = mem_rsp_data;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state, latched address and the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            rsp_valid_q <= 1'b0;
            kind_q      <= KIND_MISS;
            rdata_q     <= '0;
        end else begin
            state_q     <= state_d;
            addr_q      <= addr_d;
            rsp_valid_q <= rsp_valid_d;
            kind_q      <= kind_d;
            rdata_q     <= rdata_d;
        end
    end

    // Drive response ports from registers
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_kind  = kind_q;
        rsp_data  = rdata_q;
    end

    // Checker bookkeeping: one accepted request awaiting its response
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (fire)      pend_q <= 1'b1;
        else if (rsp_valid) pend_q <= 1'b0;
    end

    // R9
    one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!pend_q || rsp_valid));

    // R9
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> pend_q);

    // R9
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b01) |-> $past(fire));

    // R3
    phit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b10) |-> $past(fire, 2));

    // R5
    miss_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b00) |-> $past(mem_rsp_valid));

    // R5
    fill_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

endmodule

// File: rtl/pac_lookup.sv
// Module: top of the pseudo-associative lookup unit.
// Assumes: word-addressed, one word per line; the index is the low IDX_W bits
// and the stored tag is the remaining upper bits plus the top index bit.
module pac_lookup #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int TAG_W = ADDR_W - IDX_W + 1;

    logic [1:0][IDX_W-1:0]   rd_idx;
    logic [1:0]              rd_vld;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic [1:0]              hit;
    logic [TAG_W-1:0]        look_tag;
    logic [1:0]              wr_en;
    logic [1:0][IDX_W-1:0]   wr_idx;
    logic [1:0]              wr_vld;
    logic [1:0][TAG_W-1:0]   wr_tag;
    logic [1:0][DATA_W-1:0]  wr_data;

    pac_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_vld  (rd_vld),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_vld  (wr_vld),
        .wr_tag  (wr_tag),
        .wr_data (wr_data)
    );

    // One comparator per probe location: [0] primary, [1] alternate
    generate
        for (genvar p = 0; p < 2; p++) begin : g_cmp
            pac_match #(.TAG_W(TAG_W)) u_match (
                .line_vld (rd_vld[p]),
                .line_tag (rd_tag[p]),
                .want_tag (look_tag),
                .hit      (hit[p])
            );
        end
    endgenerate

    pac_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_kind      (rsp_kind),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rd_idx        (rd_idx),
        .look_tag      (look_tag),
        .hit           (hit),
        .rd_vld        (rd_vld),
        .rd_tag        (rd_tag),
        .rd_data       (rd_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_vld        (wr_vld),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !mem_req_valid));

endmodule

// File: tb/pac_lookup_test.sv
module pac_lookup_test;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int IW = 4;
    localparam int MEM_LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [DW-1:0] rsp_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int mem_count = 0;
    logic [AW-1:0] mem_last = '0;

    always #4 clk = ~clk;

    pac_lookup #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .rsp_valid (rsp_valid), .rsp_kind (rsp_kind), .rsp_data (rsp_data),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
        return DW'(32'(a) * 37 + 439);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Memory stub: answers on the MEM_LAT-th cycle of a held request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                cnt = 0;
            end else if (mem_req_valid) begin
                cnt++;
                if (cnt == MEM_LAT) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pattern(mem_req_addr);
                    mem_last      = mem_req_addr;
                    mem_count++;
                end
            end
        end
    end

    // One access with its own checks; optionally holds a stray request while busy
    task automatic access(input logic [AW-1:0] a, input logic [1:0] ek, input string req,
                          input bit stray, input logic [AW-1:0] sa);
        int cyc;
        int mc0;
        int exp_lat;
        bit busy_ok;
        busy_ok = 1'b1;
        mc0 = mem_count;
        exp_lat = (ek == 2'b01) ? 1 : (ek == 2'b10) ? 2 : 2 + MEM_LAT;
        @(negedge clk);
        check(req_ready === 1'b1, req, "ready before accept", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        cyc = 1;
        if (stray) req_addr = sa;
        else req_valid = 1'b0;
        while (!rsp_valid && cyc < 60) begin
            if (req_ready !== 1'b0) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, req, "response seen", int'(rsp_valid), 1);
        check(rsp_kind === ek, req, "kind", int'(rsp_kind), int'(ek));
        check(rsp_data === pattern(a), req, "data", int'(rsp_data), int'(pattern(a)));
        check(cyc == exp_lat, req, "latency", cyc, exp_lat);
        check(mem_count - mc0 == ((ek == 2'b00) ? 1 : 0), req, "memory requests",
              mem_count - mc0, (ek == 2'b00) ? 1 : 0);
        if (ek == 2'b00)
            check(mem_last === a, "R5", "refill address", int'(mem_last), int'(a));
        if (stray)
            check(busy_ok, "R7", "ready low while busy", int'(busy_ok), 1);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9", "single response pulse", int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(rsp_valid === 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
        check(mem_req_valid === 1'b0, "R1", "no refill after reset", int'(mem_req_valid), 0);
    endtask

    // Cold miss with a stray request held during the refill, then the stray is absent
    task automatic t_cold_and_stray();
        access(12'h123, 2'b00, "R1", 1'b1, 12'h3F7);
        access(12'h3F7, 2'b00, "R7", 1'b0, '0);
    endtask

    task automatic t_hit();
        access(12'h123, 2'b01, "R2", 1'b0, '0);
    endtask

    // Refill displaces primary into alternate; pseudo-hit then swap
    task automatic t_displace_and_swap();
        access(12'h223, 2'b00, "R6", 1'b0, '0);
        access(12'h123, 2'b10, "R3", 1'b0, '0);
        access(12'h123, 2'b01, "R4", 1'b0, '0);
        access(12'h223, 2'b10, "R4", 1'b0, '0);
    endtask

    // Refill from the other half: old alternate content is dropped
    task automatic t_drop_alternate();
        access(12'h32B, 2'b00, "R6", 1'b0, '0);
        access(12'h123, 2'b01, "R6", 1'b0, '0);
        access(12'h223, 2'b00, "R6", 1'b0, '0);
        access(12'h32B, 2'b00, "R6", 1'b0, '0);
    endtask

    // Addresses differing only in the top index bit; empty primary keeps alternate
    task automatic t_top_bit();
        access(12'h045, 2'b00, "R8", 1'b0, '0);
        access(12'h04D, 2'b00, "R8", 1'b0, '0);
        access(12'h045, 2'b01, "R8", 1'b0, '0);
        access(12'h04D, 2'b01, "R8", 1'b0, '0);
    endtask

    // Two hits accepted on consecutive cycles
    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 12'h045;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_kind === 2'b01, "R2", "first back-to-back hit",
              int'(rsp_kind), 1);
        check(rsp_data === pattern(12'h045), "R2", "first back-to-back data",
              int'(rsp_data), int'(pattern(12'h045)));
        check(req_ready === 1'b1, "R2", "ready for second", int'(req_ready), 1);
        req_addr = 12'h04D;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_kind === 2'b01, "R2", "second back-to-back hit",
              int'(rsp_kind), 1);
        check(rsp_data === pattern(12'h04D), "R2", "second back-to-back data",
              int'(rsp_data), int'(pattern(12'h04D)));
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9", "no extra response", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_and_stray();
        t_hit();
        t_displace_and_swap();
        t_drop_alternate();
        t_top_bit();
        t_back_to_back();
        summary();
        $finish;
    end
endmodule